// File: doc/BRIEF.md
# Latch-Once Countdown Watchdog

This block is a 16-bit supervisory timer for a processor subsystem. It stays idle after a power-on or external reset. The first nonzero value that software writes to its single timeout register arms it and is kept as the reload value. While armed, the counter steps down once per clock. Software must write to the register again before the count runs out. Each of those writes restores the latched value, whatever data it carries.

If the count runs out, the block raises a reset request for a fixed number of clocks and sets a sticky cause flag. It then returns to the idle state and forgets the latched timeout. The cause flag lasts through that watchdog-initiated reset, so that software coming back up can tell it from an external reset. The flag clears only on the block's own asynchronous reset input or when zero is written while the timer is idle. A zero write never arms the timer. Routing the reset request to the rest of the system is left to the surrounding logic.

Top module: `wdt_first_reload`

## Requirements
- R1: After `rst_n_i` is released, `wdt_req_o` and `wdt_cause_o` are both 0 and the timer is idle. With no writes, neither output ever rises.
- R2: A write of 0x0000 while the timer is idle does not arm it. `wdt_req_o` stays 0 for as long as no nonzero write follows.
- R3: A nonzero write while idle arms the timer with that value T. With no further writes, `wdt_req_o` rises at the T-th rising clock edge after the arming edge (T = 1 gives the very next edge).
- R4: Any write while armed, including 0x0000 or a value different from T, reloads the count to the first latched T. The written data has no other effect.
- R5: A write in the clock cycle in which the count would reach zero is treated as a reload. No reset request is raised in that cycle.
- R6: `wdt_req_o` stays high for exactly PULSE_CYCLES clock cycles (default 4). It then falls, and the timer is idle again with no latched value.
- R7: `wdt_cause_o` goes to 1 in the same cycle that `wdt_req_o` rises. It stays 1 after the request ends, and it returns to 0 only when 0x0000 is written while idle or when `rst_n_i` is asserted.
- R8: Writes made while `wdt_req_o` is high have no effect: the pulse length, `wdt_cause_o` and the later idle state are the same as without them.
- R9: After a timeout, the next nonzero write latches a new timeout value and re-arms the timer.
- R10: Asserting `rst_n_i` clears `wdt_req_o` and `wdt_cause_o` at once, without waiting for a clock edge, even during a request pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count steps once per rising edge |
| rst_n_i | input | 1 | Power-on/external reset, active low; asserts asynchronously, released synchronously inside the block |
| wr_en_i | input | 1 | Write strobe for the timeout register, one write per cycle it is high |
| wr_data_i | input | 16 | Write data; used only when the timer is idle |
| wdt_req_o | output | 1 | Reset request, high for PULSE_CYCLES clocks after a timeout |
| wdt_cause_o | output | 1 | Sticky flag marking the last reset as a watchdog timeout |

## Verification
A software reload and the expiry of the count can land in the same clock. The stimulus table places a write exactly in the cycle where the remaining count is one, and a bound property also requires that no request follows any write made while armed. The judgement is that the request stays low and the count restarts from the first latched value: the next timeout must come a full T edges later, not one edge later. A second overlap is a write, including a zero write, made during the request pulse. It is judged by the pulse keeping its length and by the cause flag staying set until a zero write is made after the timer has gone idle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_FIRE = 2'd2
  } wd_state_e;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_timeout_latch.sv
module wdt_timeout_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         capture_i,
  input  logic [W-1:0] value_i,
  output logic [W-1:0] value_o
);

  logic [W-1:0] value_q;
  logic [W-1:0] value_d;

  always_comb begin
    value_d = value_q;
    if (capture_i) begin
      value_d = value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      value_q <= '0;
    end else begin
      value_q <= value_d;
    end
  end

  assign value_o = value_q;

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         at_one_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign at_one_o = (cnt_q == ONE);

endmodule

// File: rtl/wdt_fire_stretch.sv
module wdt_fire_stretch #(
  parameter int PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic run_i,
  output logic last_o
);

  localparam int PW = (PULSE > 1) ? $clog2(PULSE) : 1;

  generate
    if (PULSE == 1) begin : g_single
      assign last_o = 1'b1;
    end else begin : g_multi
      logic [PW-1:0] left_q;
      logic [PW-1:0] left_d;

      always_comb begin
        left_d = left_q;
        if (start_i) begin
          left_d = PW'(PULSE - 1);
        end else if (run_i && (left_q != '0)) begin
          left_d = left_q - PW'(1);
        end
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          left_q <= '0;
        end else begin
          left_q <= left_d;
        end
      end

      assign last_o = (left_q == '0);
    end
  endgenerate

endmodule

// File: rtl/wdt_first_reload.sv
module wdt_first_reload #(
  parameter int W            = 16,
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wdt_req_o,
  output logic         wdt_cause_o
);

  import wdt_pkg::*;

  logic         rst_n_q;
  wd_state_e    state_q;
  wd_state_e    state_d;
  logic         cause_q;
  logic         cause_d;
  logic [W-1:0] latched_s;
  logic         at_one_s;
  logic         last_s;
  logic         idle_s;
  logic         run_s;
  logic         fire_s;
  logic         arm_s;
  logic         clear_s;
  logic         kick_s;
  logic         expire_s;
  logic         dec_s;
  logic [W-1:0] load_val_s;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_q)
  );

  always_comb begin
    idle_s   = (state_q == WD_IDLE);
    run_s    = (state_q == WD_RUN);
    fire_s   = (state_q == WD_FIRE);
    arm_s    = idle_s && wr_en_i && (wr_data_i != '0);
    clear_s  = idle_s && wr_en_i && (wr_data_i == '0);
    kick_s   = run_s && wr_en_i;
    expire_s = run_s && !wr_en_i && at_one_s;
    dec_s    = run_s && !wr_en_i && !at_one_s;
    load_val_s = arm_s ? wr_data_i : latched_s;
  end

  wdt_timeout_latch #(.W(W)) u_latch (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_q),
    .capture_i (arm_s),
    .value_i   (wr_data_i),
    .value_o   (latched_s)
  );

  wdt_down_counter #(.W(W)) u_count (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_q),
    .load_i     (arm_s || kick_s),
    .load_val_i (load_val_s),
    .dec_i      (dec_s),
    .at_one_o   (at_one_s)
  );

  wdt_fire_stretch #(.PULSE(PULSE_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_q),
    .start_i (expire_s),
    .run_i   (fire_s),
    .last_o  (last_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_IDLE: if (arm_s)    state_d = WD_RUN;
      WD_RUN:  if (expire_s) state_d = WD_FIRE;
      WD_FIRE: if (last_s)   state_d = WD_IDLE;
      default:               state_d = WD_IDLE;
    endcase
  end

  always_comb begin
    cause_d = cause_q;
    if (expire_s) begin
      cause_d = 1'b1;
    end else if (clear_s) begin
      cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q <= WD_IDLE;
      cause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign wdt_req_o   = fire_s;
  assign wdt_cause_o = cause_q;

endmodule

// File: rtl/wdt_first_reload_chk.sv
module wdt_first_reload_chk #(
  parameter int W     = 16,
  parameter int PULSE = 4
) (
  input logic         clk_i,
  input logic         rst_n_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic         run_i,
  input logic         req_i,
  input logic         cause_i
);

  logic [15:0] len_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      len_q <= '0;
    end else if (req_i) begin
      len_q <= (len_q == 16'hFFFF) ? len_q : len_q + 16'd1;
    end else begin
      len_q <= '0;
    end
  end

  // R7
  cause_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(req_i) |-> cause_i);

  // R7
  cause_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(cause_i) |-> $past(wr_en_i && (wr_data_i == '0)));

  // R5
  kick_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && wr_en_i) |=> !req_i);

  // R3
  req_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(req_i) |-> $past(run_i));

  // R6
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_i |-> (len_q < 16'(PULSE)));

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(req_i) |-> (len_q == 16'(PULSE)));

  // R8
  fire_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (req_i && wr_en_i) |=> $stable(cause_i));

endmodule

bind wdt_first_reload wdt_first_reload_chk #(
  .W     (W),
  .PULSE (PULSE_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_q),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .run_i     (run_s),
  .req_i     (wdt_req_o),
  .cause_i   (wdt_cause_o)
);

// File: tb/wdt_first_reload_test.sv
module wdt_first_reload_test;

  localparam int NV = 36;

  // fields: {req tag[3:0], wr, data[15:0], exp req, exp cause}
  localparam logic [22:0] VEC [NV] = '{
    {4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},  // R1 idle
    {4'd2, 1'b1, 16'h0000, 1'b0, 1'b0},  // R2 zero write, not armed
    {4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd3, 1'b1, 16'h0003, 1'b0, 1'b0},  // R3 arm T=3
    {4'd3, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd4, 1'b1, 16'h0001, 1'b0, 1'b0},  // R4 different data reloads 3
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd4, 1'b1, 16'h0000, 1'b0, 1'b0},  // R4 zero data reloads 3
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd5, 1'b1, 16'h00AA, 1'b0, 1'b0},  // R5 kick at count one
    {4'd5, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd5, 1'b0, 16'h0000, 1'b0, 1'b0},
    {4'd3, 1'b0, 16'h0000, 1'b1, 1'b1},  // R3 timeout
    {4'd8, 1'b1, 16'h0000, 1'b1, 1'b1},  // R8 write in pulse
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b1},  // R6 pulse ends
    {4'd7, 1'b0, 16'h0000, 1'b0, 1'b1},  // R7 sticky
    {4'd9, 1'b1, 16'h0002, 1'b0, 1'b1},  // R9 re-arm T=2
    {4'd9, 1'b0, 16'h0000, 1'b0, 1'b1},
    {4'd9, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd8, 1'b1, 16'h0005, 1'b1, 1'b1},  // R8 nonzero write in pulse
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b1},
    {4'd7, 1'b1, 16'h0000, 1'b0, 1'b0},  // R7 zero write clears cause
    {4'd3, 1'b1, 16'h0001, 1'b0, 1'b0},  // R3 arm T=1
    {4'd3, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b1},
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        req;
  logic        cause;

  int applied;
  int miscompares;
  bit done;

  wdt_first_reload uut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .wdt_req_o   (req),
    .wdt_cause_o (cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check2(input string tag, input logic a_req, input logic a_st,
                        input logic e_req, input logic e_st);
    applied++;
    if (a_req !== e_req || a_st !== e_st) begin
      miscompares++;
      $display("FAIL %s: req=%b cause=%b expected req=%b cause=%b",
               tag, a_req, a_st, e_req, e_st);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    applied = 0;
    miscompares = 0;
    done = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    check2("R1 in reset", req, cause, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check2("R1 after release", req, cause, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_en   = VEC[i][18];
      wr_data = VEC[i][17:2];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check2($sformatf("R%0d vec %0d", VEC[i][22:19], i), req, cause,
             VEC[i][1], VEC[i][0]);
    end

    // R3 long timeout: request rises exactly 1000 edges after arming
    begin
      int n;
      wr_en = 1'b1;
      wr_data = 16'd1000;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      n = 0;
      while (!req && n < 3000) begin
        @(posedge clk);
        @(negedge clk);
        n++;
      end
      applied++;
      if (n != 1000) begin
        miscompares++;
        $display("FAIL R3 long timeout: edges=%0d expected=%0d", n, 1000);
      end
    end

    // R10 asynchronous reset in the middle of the pulse
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check2("R10 async clear", req, cause, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check2("R10 after release", req, cause, 1'b0, 1'b0);

    // R1 idle long: no request without arming
    repeat (50) @(negedge clk);
    check2("R1 stays idle", req, cause, 1'b0, 1'b0);

    // R5 kick exactly at count one with T=2, repeated: never fires
    wr_en = 1'b1;
    wr_data = 16'd2;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 16'hFFFF;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check2("R5 repeated kick", req, cause, 1'b0, 1'b0);
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check2("R4 reload kept T=2", req, cause, 1'b1, 1'b1);

    finish_run();
  end

endmodule